// File: doc/BRIEF.md
# Multi-Tap Code Replica Generator

This block produces local spreading-code replicas for a bank of correlators that serves two code channels, a data channel and a pilot channel. A code oscillator keeps a code phase made of a chip index and a 32-bit chip fraction. On every input sample strobe the fraction grows by a fixed step that matches the nominal chip rate at the sample rate. When the fraction overflows, the chip index moves on by one and wraps at the end of the 4092-chip code.

Each sample yields one 51-bit word per channel. Bit k of a word holds the code chip at a fixed signed chip offset from the prompt index. The taps use only three distinct offsets, so the block does one code lookup per distinct offset and channel and then fans those chips out to the 51 taps. It does not perform 51 separate lookups.

The tracking loop writes an absolute code phase at a low rate, roughly every few milliseconds. That write is held until the next sample boundary, so no word is ever built from a mix of old and new phases. The code contents come from a computed on-chip table.

Top module: `code_replica_gen`

## Requirements
- R1: After reset the valid strobe is low, both replica words are zero, and the phase is chip index 0 with a zero fraction. The first sample after reset with no phase write uses prompt index 0.
- R2: Every cycle with the sample strobe high produces exactly one valid pulse in the following cycle. Without a sample strobe the valid strobe is low in the following cycle.
- R3: Each sample adds the step 261532830 to the 32-bit fraction. When that addition carries out, the chip index for the next sample increases by one; otherwise it is unchanged.
- R4: The chip index wraps from 4091 to 0.
- R5: Bit k of each word, for k from 0 to 50, takes the chip at index (P + (k*3)/51 − 1) mod 4092, where P is the prompt index. Taps 0–16 use P−1, taps 17–33 use P, and taps 34–50 use P+1.
- R6: The chip of channel c at index i is the XOR of all bits of the 16-bit value (i*K + (i>>2)) mod 65536. K is 40503 for the data channel and 25173 for the pilot channel.
- R7: In a phase write word, bits [31:20] give the chip index and bits [19:0] give the upper 20 fraction bits, with the lower 12 fraction bits cleared. An index field of 4092 to 4095 is reduced by 4092.
- R8: A phase write without a sample is held until the next sample. That sample's words use the written phase, and the phase then advances from it. A later write before the sample replaces an earlier one.
- R9: A phase write in the same cycle as a sample takes effect on that sample, and it overrides any write still pending.
- R10: Between samples, the replica words do not change. A pending phase write does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_i | input | 1 | Sample strobe, one replica pair per high cycle |
| ld_i | input | 1 | Phase write strobe |
| ld_phase_i | input | 32 | Absolute code phase: index [31:20], fraction [19:0] |
| rep_vld_o | output | 1 | Replica words valid, one cycle after the sample strobe |
| rep_data_o | output | 51 | Data-channel replica, bit k is tap k |
| rep_pilot_o | output | 51 | Pilot-channel replica, bit k is tap k |

## Verification
Two functions can fall in the same cycle: a phase write and a sample strobe. The bench drives them together, both with and without an earlier write still pending. The words that come out must reflect the newest written index, and not the running phase or the stale pending value. A second case covers a write that lands between samples. There the bench confirms the held words stay unchanged until the next strobe, and that the new phase then appears in full, including the tap wrap around index 0 and index 4091.

// File: rtl/crg_pkg.sv
package crg_pkg;

    localparam int          CRG_PHASE_W  = 32;
    localparam int          CRG_CODE_LEN = 4092;
    localparam int          CRG_NTAPS    = 51;
    localparam int          CRG_NLANES   = 3;
    localparam logic [31:0] CRG_STEP     = 32'd261532830;
    localparam logic [15:0] CRG_KEY_DATA  = 16'd40503;
    localparam logic [15:0] CRG_KEY_PILOT = 16'd25173;

    typedef enum logic {
        CH_DATA  = 1'b0,
        CH_PILOT = 1'b1
    } code_ch_e;

    typedef struct packed {
        logic pilot;
        logic data;
    } chip_pair_t;

    // computed code table: parity of a 16-bit hash of the chip index
    function automatic logic code_chip(code_ch_e ch, logic [15:0] idx);
        logic [15:0] key;
        logic [15:0] h;
        key = (ch == CH_DATA) ? CRG_KEY_DATA : CRG_KEY_PILOT;
        h   = idx * key + (idx >> 2);
        return ^h;
    endfunction

    // lane (distinct offset) feeding tap k
    function automatic int lane_of_tap(int k, int ntaps, int nlanes);
        return (k * nlanes) / ntaps;
    endfunction

    // signed chip offset of lane j, centred on the prompt lane
    function automatic int lane_offset(int j, int nlanes);
        return j - (nlanes - 1) / 2;
    endfunction

endpackage

// File: rtl/crg_code_rom.sv
module crg_code_rom
    import crg_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] idx_i,
    output chip_pair_t       chip_o
);

    logic [15:0] idx_ext;

    assign idx_ext     = 16'(idx_i);
    assign chip_o.data  = code_chip(CH_DATA,  idx_ext);
    assign chip_o.pilot = code_chip(CH_PILOT, idx_ext);

endmodule

// File: rtl/crg_lane_lookup.sv
module crg_lane_lookup
    import crg_pkg::*;
#(
    parameter int CODE_LEN = CRG_CODE_LEN,
    parameter int NLANES   = CRG_NLANES,
    parameter int IDX_W    = $clog2(CODE_LEN)
) (
    input  logic [IDX_W-1:0]              prm_idx_i,
    output chip_pair_t [NLANES-1:0]       lanes_o
);

    localparam int SUM_W = IDX_W + 2;
    localparam logic [SUM_W-1:0] LEN_S  = SUM_W'(CODE_LEN);
    localparam logic [SUM_W-1:0] LEN2_S = SUM_W'(2 * CODE_LEN);

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        localparam int OFF = lane_offset(j, NLANES);
        localparam logic [SUM_W-1:0] BIAS = SUM_W'(CODE_LEN + OFF);

        logic [SUM_W-1:0] raw;
        logic [SUM_W-1:0] wrapped;

        always_comb begin
            raw = {2'b00, prm_idx_i} + BIAS;
            if (raw >= LEN2_S)
                wrapped = raw - LEN2_S;
            else if (raw >= LEN_S)
                wrapped = raw - LEN_S;
            else
                wrapped = raw;
        end

        crg_code_rom #(
            .IDX_W (IDX_W)
        ) u_rom (
            .idx_i  (wrapped[IDX_W-1:0]),
            .chip_o (lanes_o[j])
        );
    end

endmodule

// File: rtl/crg_tap_fanout.sv
module crg_tap_fanout
    import crg_pkg::*;
#(
    parameter int NTAPS  = CRG_NTAPS,
    parameter int NLANES = CRG_NLANES
) (
    input  chip_pair_t [NLANES-1:0] lanes_i,
    output logic [NTAPS-1:0]        data_o,
    output logic [NTAPS-1:0]        pilot_o
);

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        localparam int L = lane_of_tap(k, NTAPS, NLANES);
        assign data_o[k]  = lanes_i[L].data;
        assign pilot_o[k] = lanes_i[L].pilot;
    end

endmodule

// File: rtl/crg_code_nco.sv
module crg_code_nco
    import crg_pkg::*;
#(
    parameter int                 PHASE_W  = CRG_PHASE_W,
    parameter int                 CODE_LEN = CRG_CODE_LEN,
    parameter logic [PHASE_W-1:0] STEP     = CRG_STEP,
    parameter int                 IDX_W    = $clog2(CODE_LEN)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               smp_i,
    input  logic               ld_i,
    input  logic [PHASE_W-1:0] ld_phase_i,
    output logic [IDX_W-1:0]   prm_idx_o
);

    localparam int FRAC_W = PHASE_W - IDX_W;
    localparam logic [IDX_W-1:0] LEN_I = IDX_W'(CODE_LEN);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(CODE_LEN - 1);

    logic [PHASE_W-1:0] acc_q;
    logic [IDX_W-1:0]   idx_q;
    logic               pend_q;
    logic [PHASE_W-1:0] pend_word_q;

    logic [PHASE_W-1:0] sel_word;
    logic               use_ld;
    logic [IDX_W-1:0]   ld_idx_raw;
    logic [IDX_W-1:0]   ld_idx;
    logic [PHASE_W-1:0] ld_acc;
    logic [IDX_W-1:0]   base_idx;
    logic [PHASE_W-1:0] base_acc;
    logic [PHASE_W:0]   sum;
    logic [IDX_W-1:0]   nxt_idx;

    always_comb begin
        // a same-cycle write is newer than a pending one
        sel_word   = ld_i ? ld_phase_i : pend_word_q;
        use_ld     = ld_i | pend_q;
        ld_idx_raw = sel_word[PHASE_W-1 -: IDX_W];
        ld_idx     = (ld_idx_raw >= LEN_I) ? (ld_idx_raw - LEN_I) : ld_idx_raw;
        ld_acc     = {sel_word[FRAC_W-1:0], {IDX_W{1'b0}}};
        base_idx   = use_ld ? ld_idx : idx_q;
        base_acc   = use_ld ? ld_acc : acc_q;
        sum        = {1'b0, base_acc} + {1'b0, STEP};
        if (!sum[PHASE_W])
            nxt_idx = base_idx;
        else if (base_idx == LAST)
            nxt_idx = '0;
        else
            nxt_idx = base_idx + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q       <= '0;
            idx_q       <= '0;
            pend_q      <= 1'b0;
            pend_word_q <= '0;
        end else if (smp_i) begin
            acc_q  <= sum[PHASE_W-1:0];
            idx_q  <= nxt_idx;
            pend_q <= 1'b0;
        end else if (ld_i) begin
            pend_q      <= 1'b1;
            pend_word_q <= ld_phase_i;
        end
    end

    assign prm_idx_o = base_idx;

    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_q < LEN_I);  // R4

    AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_i && !ld_i && !pend_q |=>
            (idx_q == $past(idx_q)) ||
            (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1)));  // R3

    AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_i |=> $stable(idx_q) && $stable(acc_q));  // R10

    AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_i |=> !pend_q);  // R8

    AST_LD_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_i && !smp_i |=> pend_q);  // R8

endmodule

// File: rtl/code_replica_gen.sv
module code_replica_gen
    import crg_pkg::*;
#(
    parameter int                 PHASE_W  = CRG_PHASE_W,
    parameter int                 CODE_LEN = CRG_CODE_LEN,
    parameter int                 NTAPS    = CRG_NTAPS,
    parameter int                 NLANES   = CRG_NLANES,
    parameter logic [PHASE_W-1:0] STEP     = CRG_STEP
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               smp_i,
    input  logic               ld_i,
    input  logic [PHASE_W-1:0] ld_phase_i,
    output logic               rep_vld_o,
    output logic [NTAPS-1:0]   rep_data_o,
    output logic [NTAPS-1:0]   rep_pilot_o
);

    localparam int IDX_W = $clog2(CODE_LEN);

    logic [IDX_W-1:0]        prm_idx;
    chip_pair_t [NLANES-1:0] lanes;
    logic [NTAPS-1:0]        fan_data;
    logic [NTAPS-1:0]        fan_pilot;

    crg_code_nco #(
        .PHASE_W  (PHASE_W),
        .CODE_LEN (CODE_LEN),
        .STEP     (STEP),
        .IDX_W    (IDX_W)
    ) u_nco (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .smp_i      (smp_i),
        .ld_i       (ld_i),
        .ld_phase_i (ld_phase_i),
        .prm_idx_o  (prm_idx)
    );

    crg_lane_lookup #(
        .CODE_LEN (CODE_LEN),
        .NLANES   (NLANES),
        .IDX_W    (IDX_W)
    ) u_lookup (
        .prm_idx_i (prm_idx),
        .lanes_o   (lanes)
    );

    crg_tap_fanout #(
        .NTAPS  (NTAPS),
        .NLANES (NLANES)
    ) u_fanout (
        .lanes_i (lanes),
        .data_o  (fan_data),
        .pilot_o (fan_pilot)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rep_vld_o   <= 1'b0;
            rep_data_o  <= '0;
            rep_pilot_o <= '0;
        end else begin
            rep_vld_o <= smp_i;
            if (smp_i) begin
                rep_data_o  <= fan_data;
                rep_pilot_o <= fan_pilot;
            end
        end
    end

    AST_VLD_AFTER_SMP: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_i |=> rep_vld_o);  // R2

    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_i |=> !rep_vld_o);  // R2

    AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_i |=> $stable(rep_data_o) && $stable(rep_pilot_o));  // R10

endmodule

// File: tb/code_replica_gen_tb.sv
module code_replica_gen_tb;

    localparam int          LEN  = 4092;
    localparam int          NT   = 51;
    localparam logic [31:0] STEP = 32'd261532830;

    // phase write word, expected prompt index
    localparam logic [43:0] VEC [6] = '{
        {32'h0010_0000, 12'd1},
        {32'hFFB0_0000, 12'd4091},
        {32'hFFC0_0000, 12'd0},
        {32'hFFF8_0000, 12'd3},
        {32'h0000_0000, 12'd0},
        {32'h7FF1_2345, 12'd2047}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp = 1'b0;
    logic        ld  = 1'b0;
    logic [31:0] ldw = '0;
    logic        rep_vld_o;
    logic [50:0] rep_data_o;
    logic [50:0] rep_pilot_o;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    int          m_idx;
    logic [31:0] m_acc;

    always #4 clk = ~clk;

    code_replica_gen u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .smp_i       (smp),
        .ld_i        (ld),
        .ld_phase_i  (ldw),
        .rep_vld_o   (rep_vld_o),
        .rep_data_o  (rep_data_o),
        .rep_pilot_o (rep_pilot_o)
    );

    function automatic logic ref_chip(bit pilot, int i);
        int          key;
        logic [15:0] hv;
        key = pilot ? 25173 : 40503;
        hv  = 16'((i * key + (i >> 2)) & 32'hFFFF);
        return ^hv;
    endfunction

    function automatic logic [50:0] exp_word(bit pilot, int idx);
        logic [50:0] w;
        for (int k = 0; k < NT; k++) begin
            int o;
            int i;
            o    = (k * 3) / NT - 1;
            i    = (idx + o + LEN) % LEN;
            w[k] = ref_chip(pilot, i);
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [50:0] act, input logic [50:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_model(input logic [31:0] w);
        int f;
        f     = int'(w[31:20]);
        m_idx = (f >= LEN) ? f - LEN : f;
        m_acc = {w[19:0], 12'h000};
    endtask

    task automatic adv_model();
        logic [32:0] s;
        s     = {1'b0, m_acc} + {1'b0, STEP};
        m_acc = s[31:0];
        if (s[32]) m_idx = (m_idx == LEN - 1) ? 0 : m_idx + 1;
    endtask

    // one sample; model must already hold the phase this sample uses
    task automatic do_sample(input bit with_ld, input logic [31:0] w, input string req);
        @(negedge clk);
        smp = 1'b1;
        ld  = with_ld;
        ldw = w;
        @(negedge clk);
        smp = 1'b0;
        ld  = 1'b0;
        chk({req, " R2 valid"}, 51'(rep_vld_o), 51'(1));
        chk({req, " R5 R6 data"},  rep_data_o,  exp_word(1'b0, m_idx));
        chk({req, " R5 R6 pilot"}, rep_pilot_o, exp_word(1'b1, m_idx));
        adv_model();
    endtask

    task automatic write_only(input logic [31:0] w);
        @(negedge clk);
        ld  = 1'b1;
        ldw = w;
        @(negedge clk);
        ld  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [50:0] hold_d;
        logic [50:0] hold_p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 51'(rep_vld_o), 51'(0));
        chk("R1 data",  rep_data_o,  '0);
        chk("R1 pilot", rep_pilot_o, '0);
        m_idx = 0;
        m_acc = '0;
        do_sample(1'b0, '0, "R1 first sample idx0");
        @(negedge clk);
        chk("R2 no valid when idle", 51'(rep_vld_o), 51'(0));

        // R3 free running advance with varied gaps
        for (int n = 0; n < 40; n++) begin
            repeat (n % 3) @(negedge clk);
            do_sample(1'b0, '0, "R3 advance");
        end

        // table walk: R7 decode, R8 held write, R9 same-cycle write
        for (int v = 0; v < 6; v++) begin
            logic [31:0] w;
            w = VEC[v][43:12];
            if (v % 2 == 0) begin
                hold_d = rep_data_o;
                hold_p = rep_pilot_o;
                write_only(w);
                repeat (2) @(negedge clk);
                chk("R10 data held", rep_data_o, hold_d);
                chk("R10 pilot held", rep_pilot_o, hold_p);
                m_idx = int'(VEC[v][11:0]);
                m_acc = {w[19:0], 12'h000};
                do_sample(1'b0, '0, "R7 R8 table");
            end else begin
                m_idx = int'(VEC[v][11:0]);
                m_acc = {w[19:0], 12'h000};
                do_sample(1'b1, w, "R7 R9 table");
            end
            do_sample(1'b0, '0, "R3 after write");
        end

        // R4 wrap from 4091 to 0
        set_model(32'hFFBF_FFFF);
        do_sample(1'b1, 32'hFFBF_FFFF, "R4 at 4091");
        chk("R4 model wrapped", 51'(m_idx), 51'(0));
        do_sample(1'b0, '0, "R4 after wrap");
        for (int n = 0; n < 20; n++) do_sample(1'b0, '0, "R3 run");

        // R8 later write replaces earlier
        write_only(32'h1230_0000);
        write_only(32'h0450_8000);
        set_model(32'h0450_8000);
        do_sample(1'b0, '0, "R8 newest pending");

        // R9 same-cycle write overrides pending one
        write_only(32'h0990_0000);
        set_model(32'h0AB4_0000);
        do_sample(1'b1, 32'h0AB4_0000, "R9 overrides pending");
        do_sample(1'b0, '0, "R9 continues");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule